// File: doc/BRIEF.md
# Host DMA Byte-Lane Sequencer

This block is the host-facing data path of an 8-bit host port that sits in front of a 24-bit processor word. It holds two 24-bit words. The outbound word is written by the processor and read by the host. The inbound word is assembled from host byte writes and taken by the processor. The host sees each word as three byte registers at addresses 5, 6 and 7. A byte-order select reverses the two outer lanes.

A two-bit transfer mode chooses how the host moves data:

- **Direct mode (`00`):** the host addresses the byte registers itself.
- **DMA modes (`01`, `10`, `11`):** the host only pulses an acknowledge strobe. An internal two-bit counter supplies the low address bits, and address bit 2 is held high. The counter starts at the mode value, steps once per byte, and reloads from the mode value after the byte at address 7. As a result, 24-, 16- or 8-bit words repeat in a circle without any host address.

The block also produces the host request output. It raises a one-cycle word event toward the processor each time a byte sequence completes at address 7.

Top module: `hdma_lane_seq`

## Requirements
- R1: `mode_sel` = 00 selects direct mode; 01, 10 and 11 select DMA with 3, 2 and 1 bytes per word. In direct mode `host_ack` moves no data, so `host_doe` stays low unless `host_cs` is high.
- R2: In DMA mode the byte address is {1, cnt}. Reset and `init_pulse` load cnt with `mode_sel`, so the first DMA byte after either one is at address 4 + `mode_sel`.
- R3: Each DMA byte transfer steps cnt by one. A transfer taken at cnt = 3 reloads cnt from `mode_sel`, so the next word repeats the same address order without an init.
- R4: Lane mapping, with lane 2 = bits 23:16, lane 1 = bits 15:8 and lane 0 = bits 7:0:
  - Big-endian: address 5 is lane 2, address 6 is lane 1, address 7 is lane 0.
  - Little-endian: address 5 is lane 0, address 6 is lane 1, address 7 is lane 2.
  - Address 4 maps to no lane.
- R5: Little-endian order applies only when `endian_le` = 1 and `hmode_fld` = 000. Every other combination uses big-endian order.
- R6: In DMA mode with `rreq_en` = 1, each `host_ack` cycle is a read: `host_doe` is high in the same cycle and `host_dout` carries the mapped outbound byte. `rreq_en` takes priority over `treq_en`.
- R7: In DMA mode with `rreq_en` = 0 and `treq_en` = 1, each `host_ack` cycle writes `host_din` into the mapped inbound lane at the clock edge, with `host_doe` low. `cpu_rdata` shows the inbound word.
- R8: In direct mode, `host_req` is the registered value of (`rreq_en` AND `rx_full`) OR (`treq_en` AND `tx_empty`), one cycle late.
- R9: Any read or write at address 7, in either mode, pulses `word_evt` high for the next cycle.
- R10: Flag behaviour:
  - `rx_full` sets on `cpu_wr` and clears after a host read at address 7; `cpu_wr` wins if both happen in the same cycle.
  - `tx_empty` clears on any host byte write to a lane and sets on `cpu_rd`; the host write wins if both happen in the same cycle.
- R11: The DMA request, one cycle late:
  - In the read direction it follows `rx_full`.
  - In the write direction it is high while `tx_empty` is set or the counter is part-way through a word, and it drops once the last byte is written.
  - It is low when neither direction is enabled.
- R12: Direct accesses (`host_cs` with `host_rd`/`host_wr`) are ignored in DMA mode. A direct read of address 4 keeps `host_doe` low.
- R13: After reset, `host_req` = 0, `rx_full` = 0, `tx_empty` = 1, `word_evt` = 0 and `host_doe` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 2 | Transfer mode / DMA word size |
| hmode_fld | input | 3 | Host-mode field; byte order honoured only at 000 |
| endian_le | input | 1 | Little-endian lane order select |
| rreq_en | input | 1 | Outbound (processor to host) request enable |
| treq_en | input | 1 | Inbound (host to processor) request enable |
| init_pulse | input | 1 | Reload DMA counter from mode_sel |
| host_cs | input | 1 | Direct access select |
| host_rd | input | 1 | Direct read strobe |
| host_wr | input | 1 | Direct write strobe |
| host_addr | input | 3 | Direct byte address |
| host_din | input | 8 | Host write byte |
| host_ack | input | 1 | DMA acknowledge strobe |
| host_dout | output | 8 | Host read byte |
| host_doe | output | 1 | Host read data enable |
| host_req | output | 1 | Host request (interrupt or DMA) |
| cpu_wr | input | 1 | Processor loads outbound word |
| cpu_wdata | input | 24 | Outbound word |
| cpu_rd | input | 1 | Processor takes inbound word |
| cpu_rdata | output | 24 | Inbound word |
| rx_full | output | 1 | Outbound word waiting for host |
| tx_empty | output | 1 | Inbound word free for host |
| word_evt | output | 1 | One-cycle full-word event |

## Verification
The assertions check the counter's preload, step and reload on every cycle. They also check that the data enable follows a DMA read acknowledge in the same cycle, that an acknowledge in direct mode moves no data, and that the word event, the outbound flag and the direct-mode request follow their causes one cycle later. Lane mapping, the gating of byte order by the host-mode field, and byte assembly into the inbound word depend on full sequences. So do the held write-direction request and the ignored direct accesses in DMA mode. The bench shows these through its sweeps over every DMA word size, both byte orders and both host-mode values, with two rounds per word so that the reload is exercised.

// File: rtl/hdma_pkg.sv
package hdma_pkg;
    localparam int BYTE_W = 8;
    localparam int LANES  = 3;
    localparam int WORD_W = BYTE_W * LANES;
    localparam int CTR_W  = 2;
    localparam int ADDR_W = CTR_W + 1;

    typedef enum logic [1:0] {
        XM_IRQ = 2'b00,
        XM_W24 = 2'b01,
        XM_W16 = 2'b10,
        XM_W8  = 2'b11
    } xfer_mode_e;

    typedef struct packed {
        logic              valid;
        logic              wr;
        logic [ADDR_W-1:0] addr;
    } xfer_t;

    localparam logic [1:0] LANE_NONE = 2'd3;

    // byte address -> lane index (2 = high byte), LANE_NONE for no lane
    function automatic logic [1:0] lane_of(input logic [ADDR_W-1:0] a, input logic little);
        case (a)
            3'd5:    lane_of = little ? 2'd0 : 2'd2;
            3'd6:    lane_of = 2'd1;
            3'd7:    lane_of = little ? 2'd2 : 2'd0;
            default: lane_of = LANE_NONE;
        endcase
    endfunction

    function automatic logic is_dma(input xfer_mode_e m);
        return m != XM_IRQ;
    endfunction
endpackage

// File: rtl/hdma_addr_ctr.sv
module hdma_addr_ctr #(
    parameter int CTR_W = hdma_pkg::CTR_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             init,
    input  logic             step,
    input  logic [CTR_W-1:0] start,
    output logic [CTR_W-1:0] cnt
);
    localparam logic [CTR_W-1:0] TOP = '1;

    always_ff @(posedge clk) begin
        if (rst || init)
            cnt <= start;
        else if (step)
            cnt <= (cnt == TOP) ? start : cnt + 1'b1;
    end
endmodule

// File: rtl/hdma_word_regs.sv
module hdma_word_regs #(
    parameter int BYTE_W = hdma_pkg::BYTE_W,
    parameter int LANES  = hdma_pkg::LANES,
    localparam int WORD_W = BYTE_W * LANES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_wr,
    input  logic [WORD_W-1:0] cpu_wdata,
    input  logic              cpu_rd,
    input  logic              xv,
    input  logic              xwr,
    input  logic [1:0]        lane,
    input  logic              last,
    input  logic [BYTE_W-1:0] din,
    output logic [BYTE_W-1:0] rd_byte,
    output logic [WORD_W-1:0] tx_word,
    output logic              rx_full,
    output logic              tx_empty,
    output logic              word_evt
);
    logic [LANES-1:0][BYTE_W-1:0] rx_q;
    logic [LANES-1:0][BYTE_W-1:0] tx_q;
    logic lane_ok;

    assign lane_ok = (lane != hdma_pkg::LANE_NONE);
    assign tx_word = tx_q;

    always_ff @(posedge clk) begin
        if (rst)
            rx_q <= '0;
        else if (cpu_wr)
            rx_q <= cpu_wdata;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_tx_lane
        always_ff @(posedge clk) begin
            if (rst)
                tx_q[g] <= '0;
            else if (xv && xwr && lane == 2'(g))
                tx_q[g] <= din;
        end
    end

    always_comb begin
        rd_byte = '0;
        for (int g = 0; g < LANES; g++)
            if (lane == 2'(g)) rd_byte = rx_q[g];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_full  <= 1'b0;
            tx_empty <= 1'b1;
            word_evt <= 1'b0;
        end else begin
            if (cpu_wr)
                rx_full <= 1'b1;
            else if (xv && !xwr && last)
                rx_full <= 1'b0;

            if (xv && xwr && lane_ok)
                tx_empty <= 1'b0;
            else if (cpu_rd)
                tx_empty <= 1'b1;

            word_evt <= xv && last;
        end
    end
endmodule

// File: rtl/hdma_req_gen.sv
module hdma_req_gen (
    input  logic clk,
    input  logic rst,
    input  logic dma_on,
    input  logic rreq_en,
    input  logic treq_en,
    input  logic rx_full,
    input  logic tx_empty,
    input  logic mid_word,
    output logic host_req
);
    logic req_d;

    always_comb begin
        if (!dma_on)
            req_d = (rreq_en && rx_full) || (treq_en && tx_empty);
        else if (rreq_en)
            req_d = rx_full;
        else if (treq_en)
            req_d = tx_empty || mid_word;
        else
            req_d = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) host_req <= 1'b0;
        else     host_req <= req_d;
    end
endmodule

// File: rtl/hdma_lane_seq.sv
module hdma_lane_seq
    import hdma_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        mode_sel,
    input  logic [2:0]        hmode_fld,
    input  logic              endian_le,
    input  logic              rreq_en,
    input  logic              treq_en,
    input  logic              init_pulse,
    input  logic              host_cs,
    input  logic              host_rd,
    input  logic              host_wr,
    input  logic [2:0]        host_addr,
    input  logic [7:0]        host_din,
    input  logic              host_ack,
    output logic [7:0]        host_dout,
    output logic              host_doe,
    output logic              host_req,
    input  logic              cpu_wr,
    input  logic [23:0]       cpu_wdata,
    input  logic              cpu_rd,
    output logic [23:0]       cpu_rdata,
    output logic              rx_full,
    output logic              tx_empty,
    output logic              word_evt
);
    xfer_mode_e        mode;
    logic              dma_on, little, dir_rd, dir_wr;
    logic [CTR_W-1:0]  cnt;
    logic              step, xfer_last, xfer_rd_last, mid_word;
    xfer_t             xfer;
    logic [1:0]        lane;
    logic [BYTE_W-1:0] rd_byte;

    assign mode   = xfer_mode_e'(mode_sel);
    assign dma_on = is_dma(mode);
    assign little = endian_le && (hmode_fld == 3'b000);
    assign dir_rd = rreq_en;
    assign dir_wr = !rreq_en && treq_en;

    always_comb begin
        if (dma_on) begin
            xfer.valid = host_ack && (dir_rd || dir_wr);
            xfer.wr    = dir_wr;
            xfer.addr  = {1'b1, cnt};
        end else begin
            xfer.valid = host_cs && (host_rd || host_wr);
            xfer.wr    = !host_rd;
            xfer.addr  = host_addr;
        end
    end

    assign step         = dma_on && xfer.valid;
    assign lane         = lane_of(xfer.addr, little);
    assign xfer_last    = xfer.valid && (xfer.addr == 3'd7);
    assign xfer_rd_last = xfer_last && !xfer.wr;
    assign mid_word     = (cnt != mode_sel);
    assign host_doe     = xfer.valid && !xfer.wr && (lane != LANE_NONE);
    assign host_dout    = host_doe ? rd_byte : '0;

    hdma_addr_ctr #(.CTR_W(CTR_W)) ctr_i (
        .clk   (clk),
        .rst   (rst),
        .init  (init_pulse),
        .step  (step),
        .start (mode_sel),
        .cnt   (cnt)
    );

    hdma_word_regs #(.BYTE_W(BYTE_W), .LANES(LANES)) regs_i (
        .clk       (clk),
        .rst       (rst),
        .cpu_wr    (cpu_wr),
        .cpu_wdata (cpu_wdata),
        .cpu_rd    (cpu_rd),
        .xv        (xfer.valid),
        .xwr       (xfer.wr),
        .lane      (lane),
        .last      (xfer_last),
        .din       (host_din),
        .rd_byte   (rd_byte),
        .tx_word   (cpu_rdata),
        .rx_full   (rx_full),
        .tx_empty  (tx_empty),
        .word_evt  (word_evt)
    );

    hdma_req_gen req_i (
        .clk      (clk),
        .rst      (rst),
        .dma_on   (dma_on),
        .rreq_en  (rreq_en),
        .treq_en  (treq_en),
        .rx_full  (rx_full),
        .tx_empty (tx_empty),
        .mid_word (mid_word),
        .host_req (host_req)
    );
endmodule

// File: rtl/hdma_lane_seq_chk.sv
module hdma_lane_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] mode_sel,
    input logic       host_cs,
    input logic       host_ack,
    input logic       rreq_en,
    input logic       host_doe,
    input logic       host_req,
    input logic       word_evt,
    input logic       rx_full,
    input logic [1:0] cnt,
    input logic       step,
    input logic       init_pulse,
    input logic       xfer_last,
    input logic       xfer_rd_last,
    input logic       cpu_wr
);
    p_irq_ack_no_data_r1: assert property (@(posedge clk) disable iff (rst)
        (mode_sel == 2'b00 && !host_cs) |-> !host_doe);

    p_ctr_preload_r2: assert property (@(posedge clk) disable iff (rst)
        init_pulse |=> (cnt == $past(mode_sel)));

    p_ctr_step_r3: assert property (@(posedge clk) disable iff (rst)
        (step && !init_pulse && cnt != 2'd3) |=> (cnt == $past(cnt) + 2'd1));

    p_ctr_reload_r3: assert property (@(posedge clk) disable iff (rst)
        (step && !init_pulse && cnt == 2'd3) |=> (cnt == $past(mode_sel)));

    p_dma_read_drive_r6: assert property (@(posedge clk) disable iff (rst)
        (mode_sel != 2'b00 && host_ack && rreq_en) |-> host_doe);

    p_irq_req_r8: assert property (@(posedge clk) disable iff (rst)
        (mode_sel == 2'b00 && rreq_en && rx_full) |=> host_req);

    p_word_evt_r9: assert property (@(posedge clk) disable iff (rst)
        xfer_last |=> word_evt);

    p_rx_set_r10: assert property (@(posedge clk) disable iff (rst)
        cpu_wr |=> rx_full);

    p_rx_clear_r10: assert property (@(posedge clk) disable iff (rst)
        (xfer_rd_last && !cpu_wr) |=> !rx_full);
endmodule

bind hdma_lane_seq hdma_lane_seq_chk chk_i (
    .clk          (clk),
    .rst          (rst),
    .mode_sel     (mode_sel),
    .host_cs      (host_cs),
    .host_ack     (host_ack),
    .rreq_en      (rreq_en),
    .host_doe     (host_doe),
    .host_req     (host_req),
    .word_evt     (word_evt),
    .rx_full      (rx_full),
    .cnt          (cnt),
    .step         (step),
    .init_pulse   (init_pulse),
    .xfer_last    (xfer_last),
    .xfer_rd_last (xfer_rd_last),
    .cpu_wr       (cpu_wr)
);

// File: tb/hdma_lane_seq_tb.sv
module hdma_lane_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  mode_sel = '0;
    logic [2:0]  hmode_fld = '0;
    logic        endian_le = 1'b0;
    logic        rreq_en = 1'b0, treq_en = 1'b0, init_pulse = 1'b0;
    logic        host_cs = 1'b0, host_rd = 1'b0, host_wr = 1'b0;
    logic [2:0]  host_addr = '0;
    logic [7:0]  host_din = '0;
    logic        host_ack = 1'b0;
    logic [7:0]  host_dout;
    logic        host_doe, host_req;
    logic        cpu_wr = 1'b0, cpu_rd = 1'b0;
    logic [23:0] cpu_wdata = '0;
    logic [23:0] cpu_rdata;
    logic        rx_full, tx_empty, word_evt;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [23:0] exp_tx = '0;

    always #10 clk = ~clk;

    hdma_lane_seq dut_i (
        .clk(clk), .rst(rst), .mode_sel(mode_sel), .hmode_fld(hmode_fld),
        .endian_le(endian_le), .rreq_en(rreq_en), .treq_en(treq_en),
        .init_pulse(init_pulse), .host_cs(host_cs), .host_rd(host_rd),
        .host_wr(host_wr), .host_addr(host_addr), .host_din(host_din),
        .host_ack(host_ack), .host_dout(host_dout), .host_doe(host_doe),
        .host_req(host_req), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
        .cpu_rd(cpu_rd), .cpu_rdata(cpu_rdata), .rx_full(rx_full),
        .tx_empty(tx_empty), .word_evt(word_evt)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    function automatic int lane_exp(input int a, input bit le, input int hm);
        bit little = le && (hm == 0);
        if (a == 5) return little ? 0 : 2;
        if (a == 6) return 1;
        if (a == 7) return little ? 2 : 0;
        return 3;
    endfunction

    task automatic cpu_load(input logic [23:0] w);
        cpu_wr = 1'b1; cpu_wdata = w;
        tick();
        cpu_wr = 1'b0;
    endtask

    task automatic pulse_init();
        init_pulse = 1'b1;
        tick();
        init_pulse = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // reset state, with both enables high so a request would show
        rreq_en = 1'b1; treq_en = 1'b1;
        repeat (3) tick();
        chk("R13 host_req", host_req, 0);
        chk("R13 rx_full", rx_full, 0);
        chk("R13 tx_empty", tx_empty, 1);
        chk("R13 word_evt", word_evt, 0);
        chk("R13 host_doe", host_doe, 0);
        rst = 1'b0; rreq_en = 1'b0; treq_en = 1'b0;
        tick();

        // DMA read sweep: every word size, both byte orders, two host-mode values
        for (int m = 1; m <= 3; m++)
            for (int le = 0; le < 2; le++)
                for (int hv = 0; hv < 2; hv++) begin
                    mode_sel = 2'(m); endian_le = le[0]; hmode_fld = hv ? 3'b100 : 3'b000;
                    rreq_en = 1'b1; treq_en = 1'b1;
                    pulse_init();
                    for (int rd = 0; rd < 2; rd++) begin
                        logic [23:0] w;
                        w = {8'(8'h10 * m + le + rd), 8'(8'h40 + hv + rd), 8'(8'h80 + 4 * m + 2 * le + rd)};
                        cpu_load(w);
                        chk("R10 rx_full set", rx_full, 1);
                        tick();
                        chk("R11 read request", host_req, 1);
                        for (int k = 0; k <= 3 - m; k++) begin
                            int a;
                            logic [7:0] eb;
                            a = 4 + m + k;
                            eb = 8'(w >> (8 * lane_exp(a, le[0], hv ? 4 : 0)));
                            host_ack = 1'b1;
                            #1;
                            chk("R6 doe on read ack", host_doe, 1);
                            if (rd == 1)      chk("R3 reload byte", host_dout, eb);
                            else if (k == 0)  chk("R2 first byte", host_dout, eb);
                            else if (hv == 1) chk("R5 byte order", host_dout, eb);
                            else              chk("R4 byte order", host_dout, eb);
                            tick();
                            host_ack = 1'b0;
                        end
                        chk("R9 word event", word_evt, 1);
                        chk("R10 rx_full clear", rx_full, 0);
                        tick();
                        chk("R9 word event drop", word_evt, 0);
                    end
                    tick();
                end

        // DMA write sweep
        for (int m = 1; m <= 3; m++)
            for (int le = 0; le < 2; le++) begin
                mode_sel = 2'(m); endian_le = le[0]; hmode_fld = 3'b000;
                rreq_en = 1'b0; treq_en = 1'b1;
                pulse_init();
                tick();
                chk("R11 write request idle", host_req, 1);
                for (int k = 0; k <= 3 - m; k++) begin
                    int a, ln;
                    logic [7:0] b;
                    a = 4 + m + k;
                    ln = lane_exp(a, le[0], 0);
                    b = 8'(8'hC0 + 16 * m + 8 * le + k);
                    host_din = b; host_ack = 1'b1;
                    #1;
                    chk("R7 no doe on write", host_doe, 0);
                    tick();
                    host_ack = 1'b0;
                    exp_tx[8 * ln +: 8] = b;
                    if (k != 3 - m) begin
                        tick();
                        chk("R11 mid-word request", host_req, 1);
                    end
                end
                chk("R9 write word event", word_evt, 1);
                chk("R10 tx_empty clear", tx_empty, 0);
                tick();
                chk("R11 request drops", host_req, 0);
                chk("R7 assembled word", cpu_rdata, exp_tx);
                cpu_rd = 1'b1;
                tick();
                cpu_rd = 1'b0;
                chk("R10 tx_empty set", tx_empty, 1);
            end

        // direct mode
        mode_sel = 2'b00; endian_le = 1'b1; hmode_fld = 3'b000;
        rreq_en = 1'b1; treq_en = 1'b0;
        cpu_load(24'hD4E5F6);
        tick();
        chk("R8 interrupt request", host_req, 1);
        host_ack = 1'b1;
        #1;
        chk("R1 ack no data", host_doe, 0);
        tick();
        host_ack = 1'b0;
        chk("R1 ack keeps rx_full", rx_full, 1);
        host_cs = 1'b1; host_rd = 1'b1; host_addr = 3'd4;
        #1;
        chk("R12 address 4 no lane", host_doe, 0);
        host_addr = 3'd5; #1; chk("R4 direct le addr5", host_dout, 8'hF6);
        host_addr = 3'd6; #1; chk("R4 direct le addr6", host_dout, 8'hE5);
        host_addr = 3'd7; #1; chk("R4 direct le addr7", host_dout, 8'hD4);
        tick();
        host_cs = 1'b0; host_rd = 1'b0;
        chk("R9 direct word event", word_evt, 1);
        chk("R10 direct rx clear", rx_full, 0);
        tick();
        chk("R8 request clears", host_req, 0);
        rreq_en = 1'b0; treq_en = 1'b1;
        tick();
        chk("R8 tx request", host_req, 1);

        endian_le = 1'b0;
        host_cs = 1'b1; host_wr = 1'b1; host_addr = 3'd5; host_din = 8'h11;
        tick();
        host_cs = 1'b0; host_wr = 1'b0;
        exp_tx[23:16] = 8'h11;
        chk("R4 direct write big", cpu_rdata, exp_tx);
        chk("R10 direct tx clear", tx_empty, 0);
        cpu_rd = 1'b1;
        tick();
        cpu_rd = 1'b0;

        // direct accesses ignored in DMA mode
        mode_sel = 2'b01; rreq_en = 1'b0; treq_en = 1'b0;
        host_cs = 1'b1; host_wr = 1'b1; host_addr = 3'd7; host_din = 8'h99;
        tick();
        host_wr = 1'b0;
        chk("R12 write ignored data", cpu_rdata, exp_tx);
        chk("R12 write ignored flag", tx_empty, 1);
        host_rd = 1'b1; host_addr = 3'd5;
        #1;
        chk("R12 read ignored", host_doe, 0);
        tick();
        host_cs = 1'b0; host_rd = 1'b0;
        chk("R12 no word event", word_evt, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule